// File: doc/BRIEF.md
# Four-Function Word ALU with Condition Flags

This block is a purely combinational arithmetic logic unit for words of a configurable width (32 bits by default). Two operand words and a two-bit function code go in. The result word and three condition bits come out: signed overflow, zero and carry/borrow. The block has no clock and no storage, so every output settles after a propagation delay whenever an input changes.

The unit offers four functions: addition, subtraction, bitwise AND and bitwise XOR. Subtraction takes the first operand away from the second. Capturing the condition bits into a state register, and turning instructions into function codes, are left to the surrounding logic.

Top module: `word_alu`

## Requirements
- R1: The block has no clock or reset input; result and flags follow any change on opnd_a, opnd_b or func_sel after propagation delay alone.
- R2: With func_sel = 2'd0 (add), result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R3: With func_sel = 2'd1 (subtract), result equals (opnd_b - opnd_a) modulo 2^WIDTH.
- R4: With func_sel = 2'd2 (and), result equals opnd_a & opnd_b.
- R5: With func_sel = 2'd3 (xor), result equals opnd_a ^ opnd_b.
- R6: zero_flag is 1 exactly when every bit of result is 0, under all four functions.
- R7: For add, carry_flag equals the carry out of the most significant bit of the unsigned sum.
- R8: For subtract, carry_flag is 1 exactly when opnd_b is smaller than opnd_a as unsigned numbers (a borrow).
- R9: For add, ovf_flag is 1 exactly when opnd_a and opnd_b have the same sign bit and the result's sign bit differs from it.
- R10: For subtract, ovf_flag is 1 exactly when opnd_b and opnd_a have different sign bits and the result's sign bit differs from that of opnd_b.
- R11: For AND and XOR, ovf_flag and carry_flag are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand; the subtrahend for subtract |
| opnd_b | input | WIDTH | Second operand; the minuend for subtract |
| func_sel | input | 2 | Function code: 0 add, 1 subtract, 2 and, 3 xor |
| result | output | WIDTH | Result word of the selected function |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out for add, borrow for subtract |

## Verification
Several flags can be raised by one operation, and the hardest case is a zero result that also carries and overflows. Adding 0x8000_0000 to itself sets carry, overflow and zero together. Subtracting equal words gives zero with no borrow. These vectors are applied directly, and the random operands are biased toward the sign-bit boundary so that flag combinations occur often. Each output field is compared on its own against a reference. The reference is built from wider signed and unsigned arithmetic, not from the sign-bit rules the design uses.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder: computes b + a, or b - a as b + ~a + 1.
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_flag_out,
  output logic             ovf_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] rhs;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    rhs            = do_sub ? ~a_in : a_in;
    wide_sum       = {1'b0, b_in} + {1'b0, rhs} + {{WIDTH{1'b0}}, do_sub};
    sum_out        = wide_sum[MSB:0];
    // a borrow is the inverse of the carry out when subtracting
    carry_flag_out = do_sub ? ~wide_sum[WIDTH] : wide_sum[WIDTH];
    ovf_out        = (b_in[MSB] == rhs[MSB]) && (sum_out[MSB] != b_in[MSB]);
  end

  always_comb begin
    if (!do_sub && !a_in[MSB] && !b_in[MSB])
      AST_ADD_POS_OVF: assert (ovf_out == sum_out[MSB]) else $error("add overflow"); // R9
    if (do_sub && !b_in[MSB] && a_in[MSB])
      AST_SUB_MIX_OVF: assert (ovf_out == sum_out[MSB]) else $error("sub overflow"); // R10
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             pick_xor,
  output logic [WIDTH-1:0] y_out
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign y_out[i] = pick_xor ? (a_in[i] ^ b_in[i]) : (a_in[i] & b_in[i]);
    end
  endgenerate
endmodule

// File: rtl/alu_zero_detect.sv
// Zero detect folded in fixed-size groups, then across groups.
module alu_zero_detect #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic [WIDTH-1:0] vec_in,
  output logic             all_zero
);
  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  assign padded = {{(PADW - WIDTH){1'b0}}, vec_in};

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      assign grp_any[g] = |padded[g*GROUP +: GROUP];
    end
  endgenerate

  assign all_zero = ~|grp_any;
endmodule

// File: rtl/word_alu.sv
module word_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf_flag,
  output logic             zero_flag,
  output logic             carry_flag
);
  alu_fn_e          fn;
  logic             is_arith;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_cf;
  logic             arith_of;

  assign fn       = alu_fn_e'(func_sel);
  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_in           (opnd_a),
    .b_in           (opnd_b),
    .do_sub         (fn == FN_SUB),
    .sum_out        (arith_res),
    .carry_flag_out (arith_cf),
    .ovf_out        (arith_of)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_in     (opnd_a),
    .b_in     (opnd_b),
    .pick_xor (fn == FN_XOR),
    .y_out    (logic_res)
  );

  assign result     = is_arith ? arith_res : logic_res;
  assign ovf_flag   = is_arith & arith_of;
  assign carry_flag = is_arith & arith_cf;

  alu_zero_detect #(.WIDTH(WIDTH), .GROUP(8)) u_zero (
    .vec_in   (result),
    .all_zero (zero_flag)
  );

  always_comb begin
    if (fn == FN_ADD)
      AST_ADD_CARRY: assert (carry_flag == (result < opnd_a)) else $error("add carry"); // R7
    if (fn == FN_SUB)
      AST_SUB_BORROW: assert (carry_flag == (opnd_b < opnd_a)) else $error("sub borrow"); // R8
    if (fn == FN_AND)
      AST_AND_SUBSET: assert ((result & ~opnd_a) == '0) else $error("and subset"); // R4
    if (fn == FN_XOR)
      AST_XOR_ZERO_EQ: assert (zero_flag == (opnd_a == opnd_b)) else $error("xor zero"); // R6
    if (!is_arith)
      AST_LOGIC_FLAGS_CLR: assert (!ovf_flag && !carry_flag) else $error("logic flags"); // R11
  end
endmodule

// File: tb/word_alu_bench.sv
module word_alu_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [1:0]   func_sel;
  logic [W-1:0] result;
  logic         ovf_flag;
  logic         zero_flag;
  logic         carry_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  word_alu #(.WIDTH(W)) u_word_alu (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .func_sel   (func_sel),
    .result     (result),
    .ovf_flag   (ovf_flag),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
  );

  // reference model from wide arithmetic
  function automatic logic [W+2:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] f);
    logic [W:0]      u;
    logic signed [W+1:0] s;
    logic [W-1:0]    r;
    logic            of, cf;
    of = 0; cf = 0;
    case (f)
      2'd0: begin
        u  = {1'b0, a} + {1'b0, b};
        r  = u[W-1:0]; cf = u[W];
        s  = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b});
        of = (s > $signed({2'b00, 1'b0, {(W-1){1'b1}}})) || (s < -$signed({2'b00, 1'b1, {(W-1){1'b0}}}));
      end
      2'd1: begin
        r  = b - a; cf = (b < a);
        s  = $signed({{2{b[W-1]}}, b}) - $signed({{2{a[W-1]}}, a});
        of = (s > $signed({2'b00, 1'b0, {(W-1){1'b1}}})) || (s < -$signed({2'b00, 1'b1, {(W-1){1'b0}}}));
      end
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    return {r, of, (r == '0), cf};
  endfunction

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f);
    logic [W+2:0] e;
    string rres, rcf, rof;
    e = ref_model(a, b, f);
    case (f)
      2'd0: begin rres = "R2"; rcf = "R7"; rof = "R9"; end
      2'd1: begin rres = "R3"; rcf = "R8"; rof = "R10"; end
      2'd2: begin rres = "R4"; rcf = "R11"; rof = "R11"; end
      default: begin rres = "R5"; rcf = "R11"; rof = "R11"; end
    endcase
    n_checks++;
    if (result !== e[W+2:3]) begin
      n_fail++;
      $display("FAIL %s result a=%h b=%h f=%0d: actual %h expected %h", rres, a, b, f, result, e[W+2:3]);
    end
    check_bit(rof, "ovf", ovf_flag, e[2]);
    check_bit("R6", "zero", zero_flag, e[1]);
    check_bit(rcf, "carry", carry_flag, e[0]);
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f);
    @(negedge clk);
    opnd_a = a; opnd_b = b; func_sel = f;
    #2;
    check_vec(a, b, f);
  endtask

  function automatic logic [W-1:0] pick_operand();
    logic [W-1:0] v;
    case ($urandom_range(0, 5))
      0: v = 32'h8000_0000;
      1: v = 32'h7FFF_FFFF;
      2: v = 32'hFFFF_FFFF;
      3: v = 32'h0000_0000;
      4: v = 32'h8000_0000 ^ ($urandom() & 32'h0000_00FF);
      default: v = $urandom();
    endcase
    return v;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    opnd_a = '0; opnd_b = '0; func_sel = 2'd0;
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // start-up state: zero inputs, add
    apply(32'h0, 32'h0, 2'd0);

    // directed corners
    apply(32'h8000_0000, 32'h8000_0000, 2'd0); // R6 R7 R9 together
    apply(32'h7FFF_FFFF, 32'h0000_0001, 2'd0); // R9 positive overflow
    apply(32'hFFFF_FFFF, 32'h0000_0001, 2'd0); // R7 carry to zero
    apply(32'h1234_5678, 32'h1234_5678, 2'd1); // R3 R6 equal, no borrow
    apply(32'h0000_0001, 32'h0000_0000, 2'd1); // R8 borrow
    apply(32'h0000_0001, 32'h8000_0000, 2'd1); // R10 min minus one
    apply(32'h8000_0000, 32'h0000_0000, 2'd1); // R10 zero minus min
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2); // R4 R11
    apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd2); // R4 R6 zero
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd3); // R5 R6 zero
    apply(32'h8000_0000, 32'h7FFF_FFFF, 2'd3); // R5 R11

    // R1: inputs change between clock edges, outputs follow with no edge
    @(posedge clk);
    #1;
    opnd_a = 32'h0000_0003; opnd_b = 32'h0000_0005; func_sel = 2'd1;
    #1;
    n_checks++;
    if (result !== 32'h0000_0002) begin
      n_fail++;
      $display("FAIL R1 mid-cycle: actual %h expected %h", result, 32'h0000_0002);
    end
    opnd_a = 32'h0000_0005;
    #1;
    check_bit("R1", "zero mid-cycle", zero_flag, 1'b1);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      apply(pick_operand(), pick_operand(), 2'($urandom_range(0, 3)));
    end

    finish_run();
  end
endmodule